// File: doc/BRIEF.md
# Reset Source Controller

This block merges three reset requests into one system reset that is released synchronously: an active-low external pin, a supply-monitor comparator and a stuck-clock watchdog. All of its logic runs on a free-running reference clock. The monitored system clock, the pin and the comparator output each pass through a two-flop synchronizer before any timing or edge detection. The watchdog treats the synchronized system clock as data. It fires when that clock shows no transition for a parameterized number of reference cycles, whether the clock is stuck high or stuck low.

Software reaches two byte-wide registers through a select/write/read port. The monitor control register holds the monitor enable and a live copy of the comparator. The reset-source register reads back a sticky record of the last reset cause. Writes to the same register set control bits: bit 1 selects the monitor as a reset source and bit 2 enables the watchdog. So a 1 written to a bit and a 1 read from it mean different things.

A monitor reset drives the pin-drive output and is released without the post-reset hold. Pin and watchdog resets incur a hold of `HOLD_CYC` reference cycles. A watchdog reset never drives the pin.

Top module: `reset_hub`

## Requirements
- R1: While `por_i` is high, `sys_rst_o` is 1, `pin_drive_o` is 0, and all enables and cause flags are cleared. After `por_i` falls, `sys_rst_o` stays high for `HOLD_CYC` cycles and is then released.
- R2: While `ext_rst_n_i` is low, `sys_rst_o` stays 1. After the pin rises, `sys_rst_o` falls on the (HOLD_CYC+3)-th rising reference edge: 2 synchronizer edges, 1 release edge and HOLD_CYC hold edges.
- R3: With the watchdog enabled, a system clock held at one level, high or low, for more than `MCD_LIMIT` reference cycles asserts `sys_rst_o`. A stall shorter than that asserts nothing. `sys_rst_o` is released once the clock toggles again.
- R4: Writing 1 to bit 2 of the source register (`reg_sel_i`=1) enables the watchdog, and writing 0 disables it. While disabled, a stuck clock causes no reset. Bit 2 reads 1 only after a watchdog reset.
- R5: A watchdog reset never asserts `pin_drive_o`.
- R6: In the control register (`reg_sel_i`=0), bit 7 is the read/write monitor enable. Bit 6 is the read-only synchronized comparator (1 = supply above threshold). Bits 5..0 read 0 and ignore writes.
- R7: A monitor reset occurs only when the monitor is enabled, selected by writing 1 to source bit 1, settled, and the comparator reads 0. `pin_drive_o` is 1 during such a reset.
- R8: After the monitor enable rises from 0 to 1, monitor resets are blocked for `SETTLE_CYC` cycles. The block restarts each time the enable rises again.
- R9: A monitor-only reset skips the hold: `sys_rst_o` falls on the 3rd rising edge after the comparator returns high.
- R10: The source register reads bit 0 = pin, bit 1 = monitor, bit 2 = watchdog. A reset sets the flags of its causes and clears all the others, and the flags persist until the next reset.
- R11: `reg_rdata_o` is registered: it shows the register picked by `reg_sel_i` one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Free-running reference clock |
| por_i | input | 1 | Synchronous active-high power-on clear |
| sys_clk_i | input | 1 | Monitored system clock, sampled as data |
| ext_rst_n_i | input | 1 | Active-low external reset pin |
| vmon_above_i | input | 1 | Comparator: 1 = supply above threshold |
| reg_sel_i | input | 1 | 0 = monitor control, 1 = reset source |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Registered read data |
| sys_rst_o | output | 1 | Synchronous system reset |
| pin_drive_o | output | 1 | Request to pull the external pin low |

## Verification
A watchdog counter that fails to clear on a transition shows up as a spurious `sys_rst_o` within `MCD_LIMIT` cycles while the clock keeps running. A counter that never saturates hides a real stall indefinitely. A wrong hold count or a wrong hold-skip decision moves the falling edge of `sys_rst_o` away from edge HOLD_CYC+3 (pin reset) or edge 3 (monitor reset), so the bench measures those edges exactly. Flags that are not cleared, or a settle window that does not restart, appear in the very next register read or as a reset raised early after the enable.

// File: rtl/reset_hub_pkg.sv
package reset_hub_pkg;
  typedef struct packed {
    logic mcd;
    logic vmon;
    logic pin;
  } cause_t;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_SRC  = 1'b1
  } reg_sel_e;

  localparam int BIT_PIN  = 0;
  localparam int BIT_VMON = 1;
  localparam int BIT_MCD  = 2;
  localparam int BIT_EN   = 7;
  localparam int BIT_LIVE = 6;
endpackage

// File: rtl/rh_sync.sv
module rh_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         por,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (por) begin
      meta <= INIT;
      q    <= INIT;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rh_clk_watch.sv
module rh_clk_watch #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic por,
  input  logic en,
  input  logic sclk,
  output logic fault_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic          prev;
  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (por) begin
      prev     <= 1'b0;
      idle_cnt <= '0;
    end else begin
      prev <= sclk;
      if (!en || (sclk != prev))
        idle_cnt <= '0;
      else if (idle_cnt != CW'(LIMIT))
        idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assign fault_o = en && (idle_cnt == CW'(LIMIT));
endmodule

// File: rtl/rh_vmon_gate.sv
module rh_vmon_gate #(
  parameter int SETTLE = 8
) (
  input  logic clk,
  input  logic por,
  input  logic en,
  input  logic sel,
  input  logic above,
  output logic hit_o
);
  localparam int SW = $clog2(SETTLE + 1);

  logic          en_q;
  logic [SW-1:0] settle_cnt;
  logic          ready;

  always_ff @(posedge clk) begin
    if (por) begin
      en_q       <= 1'b0;
      settle_cnt <= '0;
    end else begin
      en_q <= en;
      if (!en || !en_q)
        settle_cnt <= '0;
      else if (settle_cnt != SW'(SETTLE))
        settle_cnt <= settle_cnt + 1'b1;
    end
  end

  assign ready = (settle_cnt == SW'(SETTLE));
  assign hit_o = en && sel && ready && !above;
endmodule

// File: rtl/rh_sequencer.sv
module rh_sequencer
  import reset_hub_pkg::*;
#(
  parameter int HOLD = 4
) (
  input  logic   clk,
  input  logic   por,
  input  cause_t cause,
  output logic   rst_o,
  output cause_t flags_o
);
  localparam int HW = $clog2(HOLD + 1);

  logic [HW-1:0] hold_cnt;
  logic          any_req;
  logic          vmon_only;

  assign any_req   = |cause;
  assign vmon_only = cause.vmon && !cause.pin && !cause.mcd;

  always_ff @(posedge clk) begin
    if (por) begin
      rst_o    <= 1'b1;
      hold_cnt <= HW'(HOLD);
      flags_o  <= '0;
    end else if (any_req) begin
      rst_o    <= 1'b1;
      hold_cnt <= vmon_only ? '0 : HW'(HOLD);
      flags_o  <= rst_o ? (flags_o | cause) : cause;
    end else if (hold_cnt != '0) begin
      hold_cnt <= hold_cnt - 1'b1;
    end else begin
      rst_o <= 1'b0;
    end
  end
endmodule

// File: rtl/reset_hub.sv
module reset_hub
  import reset_hub_pkg::*;
#(
  parameter int MCD_LIMIT  = 16,
  parameter int SETTLE_CYC = 8,
  parameter int HOLD_CYC   = 4
) (
  input  logic       clk_ref_i,
  input  logic       por_i,
  input  logic       sys_clk_i,
  input  logic       ext_rst_n_i,
  input  logic       vmon_above_i,
  input  logic       reg_sel_i,
  input  logic       reg_wr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       sys_rst_o,
  output logic       pin_drive_o
);
  logic [2:0] sync_q;
  logic       pin_n_s, sclk_s, above_s;
  logic       vmon_en, vmon_sel, mcd_en;
  logic       pin_hit, mcd_hit, vmon_hit;
  cause_t     cause, flags;
  logic       unused_wbits;

  rh_sync #(.W(3), .INIT(3'b101)) u_sync (
    .clk (clk_ref_i),
    .por (por_i),
    .d   ({ext_rst_n_i, sys_clk_i, vmon_above_i}),
    .q   (sync_q)
  );
  assign {pin_n_s, sclk_s, above_s} = sync_q;

  always_ff @(posedge clk_ref_i) begin
    if (por_i) begin
      vmon_en  <= 1'b0;
      vmon_sel <= 1'b0;
      mcd_en   <= 1'b0;
    end else if (reg_wr_i) begin
      if (reg_sel_e'(reg_sel_i) == SEL_CTRL) begin
        vmon_en <= reg_wdata_i[BIT_EN];
      end else begin
        vmon_sel <= reg_wdata_i[BIT_VMON];
        mcd_en   <= reg_wdata_i[BIT_MCD];
      end
    end
  end
  assign unused_wbits = ^{reg_wdata_i[5:3], reg_wdata_i[0]};

  rh_clk_watch #(.LIMIT(MCD_LIMIT)) u_watch (
    .clk     (clk_ref_i),
    .por     (por_i),
    .en      (mcd_en),
    .sclk    (sclk_s),
    .fault_o (mcd_hit)
  );

  rh_vmon_gate #(.SETTLE(SETTLE_CYC)) u_vgate (
    .clk   (clk_ref_i),
    .por   (por_i),
    .en    (vmon_en),
    .sel   (vmon_sel),
    .above (above_s),
    .hit_o (vmon_hit)
  );

  assign pin_hit = !pin_n_s;
  assign cause   = '{mcd: mcd_hit, vmon: vmon_hit, pin: pin_hit};

  rh_sequencer #(.HOLD(HOLD_CYC)) u_seq (
    .clk     (clk_ref_i),
    .por     (por_i),
    .cause   (cause),
    .rst_o   (sys_rst_o),
    .flags_o (flags)
  );

  always_ff @(posedge clk_ref_i) begin
    if (por_i) begin
      pin_drive_o <= 1'b0;
      reg_rdata_o <= '0;
    end else begin
      pin_drive_o <= vmon_hit;
      if (reg_sel_e'(reg_sel_i) == SEL_SRC)
        reg_rdata_o <= {5'b0, flags.mcd, flags.vmon, flags.pin};
      else
        reg_rdata_o <= {vmon_en, above_s, 6'b0};
    end
  end
endmodule

// File: rtl/reset_hub_checker.sv
module reset_hub_checker (
  input logic       clk,
  input logic       por,
  input logic       sys_rst_o,
  input logic       pin_drive_o,
  input logic       reg_sel_i,
  input logic [7:0] reg_rdata_o,
  input logic       pin_hit,
  input logic       mcd_hit,
  input logic       vmon_hit,
  input logic       vmon_en,
  input logic       vmon_sel,
  input logic       mcd_en
);
  a_r1_por_holds_reset: assert property (@(posedge clk) por |=> sys_rst_o);

  a_r2_pin_holds_reset: assert property (@(posedge clk) disable iff (por)
    pin_hit |=> sys_rst_o);

  a_r3_mcd_holds_reset: assert property (@(posedge clk) disable iff (por)
    mcd_hit |=> sys_rst_o);

  a_r4_mcd_off_silent: assert property (@(posedge clk) disable iff (por)
    !mcd_en |-> !mcd_hit);

  a_r5_mcd_no_pin: assert property (@(posedge clk) disable iff (por)
    (mcd_hit && !vmon_hit) |=> !pin_drive_o);

  a_r6_ctrl_low_bits_zero: assert property (@(posedge clk) disable iff (por)
    !reg_sel_i |=> (reg_rdata_o[5:0] == 6'b0));

  a_r7_vmon_gated: assert property (@(posedge clk) disable iff (por)
    vmon_hit |-> (vmon_en && vmon_sel));

  a_r8_settle_blocks: assert property (@(posedge clk) disable iff (por)
    $rose(vmon_en) |=> !vmon_hit);

  a_r9_release_quiet: assert property (@(posedge clk) disable iff (por)
    $fell(sys_rst_o) |-> !$past(pin_hit || mcd_hit || vmon_hit));
endmodule

bind reset_hub reset_hub_checker u_chk (
  .clk         (clk_ref_i),
  .por         (por_i),
  .sys_rst_o   (sys_rst_o),
  .pin_drive_o (pin_drive_o),
  .reg_sel_i   (reg_sel_i),
  .reg_rdata_o (reg_rdata_o),
  .pin_hit     (pin_hit),
  .mcd_hit     (mcd_hit),
  .vmon_hit    (vmon_hit),
  .vmon_en     (vmon_en),
  .vmon_sel    (vmon_sel),
  .mcd_en      (mcd_en)
);

// File: tb/reset_hub_test.sv
module reset_hub_test;
  localparam int PERIOD = 10;
  localparam int HOLD   = 4;

  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       sys_clk = 1'b0;
  logic       ext_n = 1'b1;
  logic       above = 1'b1;
  logic       sel = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sys_rst, pin_drv;
  logic       sc_run = 1'b1;
  int         n_run = 0;
  int         n_fail = 0;

  always #(PERIOD/2) clk = ~clk;
  always @(negedge clk) if (sc_run) sys_clk <= ~sys_clk;

  reset_hub #(.MCD_LIMIT(16), .SETTLE_CYC(8), .HOLD_CYC(HOLD)) uut (
    .clk_ref_i    (clk),
    .por_i        (por),
    .sys_clk_i    (sys_clk),
    .ext_rst_n_i  (ext_n),
    .vmon_above_i (above),
    .reg_sel_i    (sel),
    .reg_wr_i     (wr),
    .reg_wdata_i  (wdata),
    .reg_rdata_o  (rdata),
    .sys_rst_o    (sys_rst),
    .pin_drive_o  (pin_drv)
  );

  // {sel, wdata[7:0], comparator, expected read[7:0]}
  localparam logic [17:0] VEC [7] = '{
    {1'b0, 8'hFF, 1'b1, 8'hC0},
    {1'b0, 8'h00, 1'b1, 8'h40},
    {1'b0, 8'h3F, 1'b0, 8'h00},
    {1'b0, 8'h80, 1'b1, 8'hC0},
    {1'b1, 8'h04, 1'b1, 8'h00},
    {1'b1, 8'h00, 1'b1, 8'h00},
    {1'b0, 8'h00, 1'b1, 8'h40}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic s, input logic [7:0] d);
    @(negedge clk);
    sel = s; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic s, output logic [7:0] d);
    @(negedge clk);
    sel = s;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic edges_to_release(output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (sys_rst && n < 60);
  endtask

  task automatic stall_at(input logic lvl);
    do begin
      @(posedge clk);
      #1;
    end while (sys_clk != lvl);
    sc_run = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int n;
    cyc(5);
    chk("R1 reset during por", {7'b0, sys_rst}, 8'h01);
    chk("R1 pin drive during por", {7'b0, pin_drv}, 8'h00);
    por = 1'b0;
    cyc(2);
    chk("R1 hold after por", {7'b0, sys_rst}, 8'h01);
    cyc(10);
    chk("R1 released", {7'b0, sys_rst}, 8'h00);
    rd_reg(1'b1, r);
    chk("R1 flags clear", r, 8'h00);

    for (int i = 0; i < 7; i++) begin
      above = VEC[i][8];
      wr_reg(VEC[i][17], VEC[i][16:9]);
      cyc(4);
      rd_reg(VEC[i][17], r);
      chk($sformatf("R6 R4 R11 vector %0d", i), r, VEC[i][7:0]);
    end
    chk("R11 no reset from vectors", {7'b0, sys_rst}, 8'h00);

    // R2: external pin
    @(negedge clk); ext_n = 1'b0;
    cyc(12);
    chk("R2 pin reset held", {7'b0, sys_rst}, 8'h01);
    chk("R2 pin reset no drive", {7'b0, pin_drv}, 8'h00);
    ext_n = 1'b1;
    edges_to_release(n);
    chk("R2 release edge", 8'(n), 8'(HOLD + 3));
    rd_reg(1'b1, r);
    chk("R10 pin flag", r, 8'h01);

    // R4: stuck clock with watchdog disabled
    stall_at(1'b1);
    cyc(40);
    chk("R4 disabled no reset", {7'b0, sys_rst}, 8'h00);
    sc_run = 1'b1;
    cyc(4);

    // R3: stuck high
    wr_reg(1'b1, 8'h04);
    rd_reg(1'b1, r);
    chk("R4 bit2 reads flag not enable", r, 8'h01);
    stall_at(1'b1);
    cyc(8);
    chk("R3 short stall no reset", {7'b0, sys_rst}, 8'h00);
    cyc(25);
    chk("R3 stuck high reset", {7'b0, sys_rst}, 8'h01);
    chk("R5 watchdog no pin drive", {7'b0, pin_drv}, 8'h00);
    sc_run = 1'b1;
    cyc(20);
    chk("R3 released after toggling", {7'b0, sys_rst}, 8'h00);
    rd_reg(1'b1, r);
    chk("R10 R4 watchdog flag only", r, 8'h04);

    // R3: stuck low
    stall_at(1'b0);
    cyc(33);
    chk("R3 stuck low reset", {7'b0, sys_rst}, 8'h01);
    chk("R5 stuck low no pin drive", {7'b0, pin_drv}, 8'h00);
    sc_run = 1'b1;
    cyc(20);
    wr_reg(1'b1, 8'h00);

    // R7: monitor gating
    @(negedge clk); above = 1'b0;
    cyc(10);
    chk("R7 not enabled not selected", {7'b0, sys_rst}, 8'h00);
    wr_reg(1'b1, 8'h02);
    cyc(10);
    chk("R7 selected but disabled", {7'b0, sys_rst}, 8'h00);
    wr_reg(1'b0, 8'h80);
    cyc(3);
    chk("R8 settle blocks", {7'b0, sys_rst}, 8'h00);
    cyc(20);
    chk("R7 monitor reset", {7'b0, sys_rst}, 8'h01);
    chk("R7 monitor drives pin", {7'b0, pin_drv}, 8'h01);
    rd_reg(1'b1, r);
    chk("R10 monitor flag only", r, 8'h02);
    above = 1'b1;
    edges_to_release(n);
    chk("R9 monitor release edge", 8'(n), 8'd3);

    // R8: settle restarts on re-enable
    wr_reg(1'b0, 8'h00);
    @(negedge clk); above = 1'b0;
    cyc(20);
    chk("R7 disabled monitor silent", {7'b0, sys_rst}, 8'h00);
    wr_reg(1'b0, 8'h80);
    cyc(3);
    chk("R8 settle restarts", {7'b0, sys_rst}, 8'h00);
    cyc(20);
    chk("R8 reset after settle", {7'b0, sys_rst}, 8'h01);
    above = 1'b1;
    cyc(10);

    // R10: a pin reset clears the monitor flag
    @(negedge clk); ext_n = 1'b0;
    cyc(10);
    ext_n = 1'b1;
    cyc(12);
    rd_reg(1'b1, r);
    chk("R10 pin flag clears monitor flag", r, 8'h01);
    rd_reg(1'b0, r);
    chk("R6 enable kept live high", r, 8'hC0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule